// File: doc/BRIEF.md
# Modeline Video Address Generator

This block forms the two display-fetch addresses that a video controller issues in every memory cycle of a scanline. A scanline is 57 memory cycles long, and each memory cycle has two display slots. The block holds two 16-bit line data pointers, called pointer A and pointer B. At the start of each modeline it takes in a parameter set: the scanline count, the mode bits, the left and right margins, and both pointer bases. For every scanline of that modeline it then decides which pointer addresses each slot, when each pointer steps, and when a pointer returns to its base.

An outside sequencer supplies the cycle position. It pulses `mc_tick` once per memory cycle and gives the cycle number on `mc_index`. In the character modes, the byte read in slot A is the glyph index, and it comes back on `idx_byte` so that the slot-B font address can be formed in the same cycle. The addresses and enables are combinational outputs. They are derived from the pointer state and the current cycle number, and they stay stable for the whole memory cycle. The pointers update on the clock edge at which `mc_tick` is high.

The parameter set is loaded with `prm_load`. The load must fall after the cycle-0 strobe of the modeline's first scanline and before cycle 8. `prm_load` must never be high in the same clock as `mc_tick`.

Top module: `modeline_addr_gen`

## Requirements
- R1: After reset, `fa_en`, `fb_en`, `sync_win` and `ml_end` are all 0.
- R2: The mode field is `prm_mode[3:1]`. Its codes are: 000 sync band, 001 full bitmap, 010 cell attribute, 011 glyph-256, 100 glyph-128, 101 glyph-64, 110 reserved, 111 half bitmap. In sync band mode neither slot fetches, and `sync_win` is 1 exactly for cycles c with LM <= c < RM.
- R3: In full bitmap mode, slot A reads pointer A and slot B reads pointer A + 1. Pointer A steps by 2 per active cycle.
- R4: In half bitmap mode, slot A reads pointer A and pointer A steps by 1 per active cycle. Slot B is never enabled.
- R5: In cell attribute mode, slot A reads pointer A, which steps once per active cycle and returns to its base at each scanline start. Slot B reads pointer B, which steps once per active cycle and carries on across the scanlines of the modeline.
- R6: In the glyph modes, slot A reads pointer A (the glyph index). The slot-B address is formed from pointer B (PB) and the index byte (IDX) as follows:
  - glyph-256: {PB[7:0], IDX[7:0]}
  - glyph-128: {PB[8:0], IDX[6:0]}
  - glyph-64: {PB[9:0], IDX[5:0]}
- R7: In the glyph modes, pointer A returns to its base at each scanline start and steps once per active cycle. Pointer B steps by 1 at the start of each scanline after the first.
- R8: A cycle c is active only when LM <= c < RM, with the margins taken from `prm_lmarg` and `prm_rmarg`. Pointers step and slots fetch only in active cycles.
- R9: Cycles 0 to 7 and 54 to 56 never fetch, whatever the margins are.
- R10: When `prm_mode[4]` is 0 (repeat), both pointers return to their bases at every scanline start. Every scanline of the modeline then fetches the same addresses.
- R11: `prm_count` is a two's-complement scanline count. `ml_end` pulses for one clock, in the clock after the cycle-56 strobe of the modeline's last scanline. A count of 0xFF ends the modeline after one scanline, and 0xFE after two.
- R12: In reserved mode 110, no slot fetches and `sync_win` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prm_load | input | 1 | Loads the parameter set |
| prm_count | input | 8 | Two's-complement scanline count |
| prm_mode | input | 4 | Bit 4 = continue (1) or repeat (0); bits 3..1 = mode field |
| prm_lmarg | input | 6 | Left margin cycle |
| prm_rmarg | input | 6 | Right margin cycle (exclusive) |
| prm_ptr_a | input | 16 | Base of pointer A |
| prm_ptr_b | input | 16 | Base of pointer B |
| mc_tick | input | 1 | One pulse per memory cycle |
| mc_index | input | 6 | Memory cycle number within the scanline |
| idx_byte | input | 8 | Byte read in slot A (the glyph index) |
| fa_addr | output | 16 | Slot-A address |
| fb_addr | output | 16 | Slot-B address |
| fa_en | output | 1 | Slot-A fetch enable |
| fb_en | output | 1 | Slot-B fetch enable |
| sync_win | output | 1 | Sync band window between the margins |
| ml_end | output | 1 | End-of-modeline pulse |

## Verification
Each mode is run over whole scanlines against a bench model of the pointers. This separates the two step sizes of the bitmap modes and the pointer that carries on across scanlines in cell mode from the one that restarts. A two-scanline glyph-256 run varies the index byte from cycle to cycle, so any error in the index bits or in the once-per-scanline step of pointer B shows up. Glyph-128 and glyph-64 runs use pointer-B bases with high bits set, which catches a wrong splice width. Margin settings that cover the reserved cycles, and repeat-mode runs of two and three scanlines, separate margin gating from reserved-cycle gating and reload from carry-on. Counts of 0xFF, 0xFE and 0xFD place the end pulse after the correct scanline.

// File: rtl/mla_pkg.sv
package mla_pkg;

  // Mode field codes (parameter bits 3..1).
  typedef enum logic [2:0] {
    VM_SYNC    = 3'b000,
    VM_BITMAP  = 3'b001,
    VM_CELL    = 3'b010,
    VM_GLY256  = 3'b011,
    VM_GLY128  = 3'b100,
    VM_GLY64   = 3'b101,
    VM_RSVD    = 3'b110,
    VM_HALFBMP = 3'b111
  } vmode_e;

  function automatic logic is_glyph(vmode_e m);
    return (m == VM_GLY256) || (m == VM_GLY128) || (m == VM_GLY64);
  endfunction

endpackage

// File: rtl/mla_window.sv
module mla_window #(
  parameter int IW    = 6,
  parameter int FIRST = 8,
  parameter int LAST  = 53
) (
  input  logic [IW-1:0] idx,
  input  logic [IW-1:0] lmarg,
  input  logic [IW-1:0] rmarg,
  output logic          in_margin,
  output logic          in_zone
);
  localparam logic [IW-1:0] FIRST_V = IW'(FIRST);
  localparam logic [IW-1:0] LAST_V  = IW'(LAST);

  always_comb begin
    in_margin = (idx >= lmarg) && (idx < rmarg);
    in_zone   = (idx >= FIRST_V) && (idx <= LAST_V);
  end
endmodule

// File: rtl/mla_ptr.sv
module mla_ptr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_a,
  input  logic [AW-1:0] load_b,
  input  logic [AW-1:0] base_a,
  input  logic [AW-1:0] base_b,
  input  logic          reload_a,
  input  logic          reload_b,
  input  logic          line_bump_b,
  input  logic          adv_en,
  input  logic [1:0]    step_a,
  input  logic          step_b,
  output logic [AW-1:0] ptr_a,
  output logic [AW-1:0] ptr_b
);
  logic [AW-1:0] ptr_a_d, ptr_b_d;
  logic          ptr_we;

  always_comb begin
    ptr_a_d = ptr_a;
    ptr_b_d = ptr_b;
    if (load) begin
      ptr_a_d = load_a;
      ptr_b_d = load_b;
    end else begin
      if (reload_a)      ptr_a_d = base_a;
      else if (adv_en)   ptr_a_d = ptr_a + AW'(step_a);
      if (reload_b)                ptr_b_d = base_b;
      else if (line_bump_b)        ptr_b_d = ptr_b + AW'(1);
      else if (adv_en && step_b)   ptr_b_d = ptr_b + AW'(1);
    end
    ptr_we = load | reload_a | reload_b | line_bump_b | adv_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_a <= '0;
      ptr_b <= '0;
    end else if (ptr_we) begin
      ptr_a <= ptr_a_d;
      ptr_b <= ptr_b_d;
    end
  end
endmodule

// File: rtl/mla_linecnt.sv
module mla_linecnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] init,
  input  logic          line_done,
  output logic          end_pulse
);
  logic [CW-1:0] cnt, cnt_d;
  logic          end_d;

  always_comb begin
    cnt_d = cnt;
    if (load)           cnt_d = init;
    else if (line_done) cnt_d = cnt + CW'(1);
    end_d = !load && line_done && (cnt == {CW{1'b1}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      end_pulse <= 1'b0;
    end else begin
      if (load || line_done) cnt <= cnt_d;
      end_pulse <= end_d;
    end
  end
endmodule

// File: rtl/mla_addr_mux.sv
module mla_addr_mux
  import mla_pkg::*;
#(
  parameter int AW = 16
) (
  input  vmode_e        mode,
  input  logic [AW-1:0] ptr_a,
  input  logic [AW-1:0] ptr_b,
  input  logic [7:0]    idx_byte,
  output logic [AW-1:0] addr_a,
  output logic [AW-1:0] addr_b
);
  always_comb begin
    addr_a = ptr_a;
    case (mode)
      VM_BITMAP: addr_b = ptr_a + AW'(1);
      VM_CELL:   addr_b = ptr_b;
      VM_GLY256: addr_b = {ptr_b[AW-9:0], idx_byte};
      VM_GLY128: addr_b = {ptr_b[AW-8:0], idx_byte[6:0]};
      VM_GLY64:  addr_b = {ptr_b[AW-7:0], idx_byte[5:0]};
      default:   addr_b = ptr_a;
    endcase
  end
endmodule

// File: rtl/modeline_addr_gen.sv
module modeline_addr_gen
  import mla_pkg::*;
#(
  parameter int AW          = 16,
  parameter int LINE_CYCLES = 57,
  parameter int HEAD_CYCLES = 8,
  parameter int TAIL_CYCLES = 3,
  parameter int CNT_W       = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           prm_load,
  input  logic [CNT_W-1:0]               prm_count,
  input  logic [4:1]                     prm_mode,
  input  logic [$clog2(LINE_CYCLES)-1:0] prm_lmarg,
  input  logic [$clog2(LINE_CYCLES)-1:0] prm_rmarg,
  input  logic [AW-1:0]                  prm_ptr_a,
  input  logic [AW-1:0]                  prm_ptr_b,
  input  logic                           mc_tick,
  input  logic [$clog2(LINE_CYCLES)-1:0] mc_index,
  input  logic [7:0]                     idx_byte,
  output logic [AW-1:0]                  fa_addr,
  output logic [AW-1:0]                  fb_addr,
  output logic                           fa_en,
  output logic                           fb_en,
  output logic                           sync_win,
  output logic                           ml_end
);
  localparam int IW        = $clog2(LINE_CYCLES);
  localparam int FIRST_CYC = HEAD_CYCLES;
  localparam int LAST_CYC  = LINE_CYCLES - TAIL_CYCLES - 1;
  localparam logic [IW-1:0] END_IDX = IW'(LINE_CYCLES - 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync, rst_meta} <= 2'b00;
    else        {rst_sync, rst_meta} <= {rst_meta, 1'b1};
  end

  // modeline parameter holding registers
  vmode_e        mode_q;
  logic          cont_q;
  logic [IW-1:0] lm_q, rm_q;
  logic [AW-1:0] base_a_q, base_b_q;

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      mode_q   <= VM_SYNC;
      cont_q   <= 1'b1;
      lm_q     <= '0;
      rm_q     <= '0;
      base_a_q <= '0;
      base_b_q <= '0;
    end else if (prm_load) begin
      mode_q   <= vmode_e'(prm_mode[3:1]);
      cont_q   <= prm_mode[4];
      lm_q     <= prm_lmarg;
      rm_q     <= prm_rmarg;
      base_a_q <= prm_ptr_a;
      base_b_q <= prm_ptr_b;
    end
  end

  // cycle position decode
  logic in_margin, in_zone, active, line_start, line_last;

  mla_window #(.IW(IW), .FIRST(FIRST_CYC), .LAST(LAST_CYC)) u_win (
    .idx       (mc_index),
    .lmarg     (lm_q),
    .rmarg     (rm_q),
    .in_margin (in_margin),
    .in_zone   (in_zone)
  );

  // mode-dependent control
  logic       md_bitmap, md_half, md_cell, md_glyph, md_sync;
  logic       fetch_a, fetch_b, adv_en;
  logic       reload_a, reload_b, line_bump_b;
  logic [1:0] step_a;

  always_comb begin
    active      = in_margin && in_zone;
    line_start  = mc_tick && (mc_index == '0);
    line_last   = mc_tick && (mc_index == END_IDX);
    md_bitmap   = (mode_q == VM_BITMAP);
    md_half     = (mode_q == VM_HALFBMP);
    md_cell     = (mode_q == VM_CELL);
    md_glyph    = is_glyph(mode_q);
    md_sync     = (mode_q == VM_SYNC);
    fetch_a     = active && (md_bitmap || md_half || md_cell || md_glyph);
    fetch_b     = active && (md_bitmap || md_cell || md_glyph);
    step_a      = md_bitmap ? 2'd2 : (fetch_a ? 2'd1 : 2'd0);
    adv_en      = mc_tick && fetch_a;
    reload_a    = line_start && (!cont_q || md_cell || md_glyph);
    reload_b    = line_start && !cont_q;
    line_bump_b = line_start && cont_q && md_glyph;
  end

  logic [AW-1:0] ptr_a, ptr_b;

  mla_ptr #(.AW(AW)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_sync),
    .load        (prm_load),
    .load_a      (prm_ptr_a),
    .load_b      (prm_ptr_b),
    .base_a      (base_a_q),
    .base_b      (base_b_q),
    .reload_a    (reload_a),
    .reload_b    (reload_b),
    .line_bump_b (line_bump_b),
    .adv_en      (adv_en),
    .step_a      (step_a),
    .step_b      (md_cell),
    .ptr_a       (ptr_a),
    .ptr_b       (ptr_b)
  );

  mla_linecnt #(.CW(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync),
    .load      (prm_load),
    .init      (prm_count),
    .line_done (line_last),
    .end_pulse (ml_end)
  );

  mla_addr_mux #(.AW(AW)) u_mux (
    .mode     (mode_q),
    .ptr_a    (ptr_a),
    .ptr_b    (ptr_b),
    .idx_byte (idx_byte),
    .addr_a   (fa_addr),
    .addr_b   (fb_addr)
  );

  always_comb begin
    fa_en    = fetch_a;
    fb_en    = fetch_b;
    sync_win = md_sync && in_margin;
  end
endmodule

// File: rtl/mla_chk.sv
module mla_chk #(
  parameter int AW    = 16,
  parameter int IW    = 6,
  parameter int FIRST = 8,
  parameter int LAST  = 53
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mc_tick,
  input logic [IW-1:0] mc_index,
  input logic          prm_load,
  input logic          fa_en,
  input logic          fb_en,
  input logic [AW-1:0] fa_addr,
  input logic          sync_win,
  input logic          ml_end,
  input logic [2:0]    mode_q
);
  // R9: reserved cycles never fetch
  a_r9_no_fetch_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    ((mc_index < IW'(FIRST)) || (mc_index > IW'(LAST))) |-> (!fa_en && !fb_en));

  // R4: half bitmap never enables slot B
  a_r4_half_no_b: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'b111) |-> !fb_en);

  // R3: full bitmap pointer steps by two per fetched cycle
  a_r3_bitmap_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_tick && fa_en && (mode_q == 3'b001) && !prm_load) |=> (fa_addr == $past(fa_addr) + AW'(2)));

  // R2: sync band window excludes fetches
  a_r2_sync_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    sync_win |-> (!fa_en && !fb_en));

  // R11: end pulse lasts one clock
  a_r11_end_single: assert property (@(posedge clk) disable iff (!rst_n)
    ml_end |=> !ml_end);

  // R8: slot B only fetches in a cycle where slot A does
  a_r8_b_with_a: assert property (@(posedge clk) disable iff (!rst_n)
    fb_en |-> fa_en);
endmodule

bind modeline_addr_gen mla_chk #(.AW(AW), .IW(IW), .FIRST(FIRST_CYC), .LAST(LAST_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mc_tick  (mc_tick),
  .mc_index (mc_index),
  .prm_load (prm_load),
  .fa_en    (fa_en),
  .fb_en    (fb_en),
  .fa_addr  (fa_addr),
  .sync_win (sync_win),
  .ml_end   (ml_end),
  .mode_q   (mode_q)
);

// File: tb/tb_modeline_addr_gen.sv
module tb_modeline_addr_gen;
  logic        clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, prm_load, mc_tick;
  logic [7:0]  prm_count, idx_byte;
  logic [4:1]  prm_mode;
  logic [5:0]  prm_lmarg, prm_rmarg, mc_index;
  logic [15:0] prm_ptr_a, prm_ptr_b, fa_addr, fb_addr;
  logic        fa_en, fb_en, sync_win, ml_end;

  modeline_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .prm_load(prm_load), .prm_count(prm_count),
    .prm_mode(prm_mode), .prm_lmarg(prm_lmarg), .prm_rmarg(prm_rmarg),
    .prm_ptr_a(prm_ptr_a), .prm_ptr_b(prm_ptr_b), .mc_tick(mc_tick),
    .mc_index(mc_index), .idx_byte(idx_byte), .fa_addr(fa_addr),
    .fb_addr(fb_addr), .fa_en(fa_en), .fb_en(fb_en), .sync_win(sync_win),
    .ml_end(ml_end)
  );

  typedef struct {
    bit          ea, eb, sy;
    logic [15:0] a, b;
    int          c;
    string       req;
  } exp_t;

  exp_t q[$];
  int   total = 0, bad = 0;
  bit   done = 0;

  // modeline under test
  logic [7:0]  g_sc;
  logic [4:1]  g_mb;
  logic [5:0]  g_lm, g_rm;
  logic [15:0] g_b1, g_b2, p1, p2;
  string       g_req;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops one expected item per strobed cycle
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (mc_tick && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(fa_en == e.ea, e.req, $sformatf("fa_en c%0d", e.c), fa_en, e.ea);
        chk(fb_en == e.eb, e.req, $sformatf("fb_en c%0d", e.c), fb_en, e.eb);
        chk(sync_win == e.sy, e.req, $sformatf("sync_win c%0d", e.c), sync_win, e.sy);
        if (e.ea) chk(fa_addr == e.a, e.req, $sformatf("fa_addr c%0d", e.c), fa_addr, e.a);
        if (e.eb) chk(fb_addr == e.b, e.req, $sformatf("fb_addr c%0d", e.c), fb_addr, e.b);
      end
    end
  end

  task automatic setup(input logic [7:0] sc, input logic [4:1] mb, input logic [5:0] lm,
                       input logic [5:0] rm, input logic [15:0] b1, input logic [15:0] b2,
                       input string req);
    g_sc = sc; g_mb = mb; g_lm = lm; g_rm = rm; g_b1 = b1; g_b2 = b2; g_req = req;
  endtask

  task automatic do_load();
    @(negedge clk);
    mc_tick = 1'b0;
    prm_count = g_sc; prm_mode = g_mb; prm_lmarg = g_lm; prm_rmarg = g_rm;
    prm_ptr_a = g_b1; prm_ptr_b = g_b2;
    prm_load = 1'b1;
    @(negedge clk);
    prm_load = 1'b0;
  endtask

  // driver: one memory cycle, expected item computed from the requirements
  task automatic cyc(input int c);
    exp_t e;
    logic [2:0] m;
    bit inm, act;
    logic [7:0] byt;
    m   = g_mb[3:1];
    byt = 8'(c * 37 + 5);
    inm = (c >= int'(g_lm)) && (c < int'(g_rm));
    act = inm && (c >= 8) && (c <= 53);
    e.c = c; e.req = g_req; e.sy = 0; e.ea = 0; e.eb = 0; e.a = p1; e.b = p1;
    case (m)
      3'd0: e.sy = inm;
      3'd1: begin e.ea = act; e.eb = act; e.b = p1 + 16'd1; if (act) p1 = p1 + 16'd2; end
      3'd7: begin e.ea = act; if (act) p1 = p1 + 16'd1; end
      3'd2: begin e.ea = act; e.eb = act; e.b = p2; if (act) begin p1 = p1 + 16'd1; p2 = p2 + 16'd1; end end
      3'd3, 3'd4, 3'd5: begin
        e.ea = act; e.eb = act;
        if (m == 3'd3)      e.b = {p2[7:0], byt};
        else if (m == 3'd4) e.b = {p2[8:0], byt[6:0]};
        else                e.b = {p2[9:0], byt[5:0]};
        if (act) p1 = p1 + 16'd1;
      end
      default: ;
    endcase
    @(negedge clk);
    mc_tick = 1'b1; mc_index = 6'(c); idx_byte = byt;
    q.push_back(e);
  endtask

  task automatic run_line(input bit first, input bit exp_end);
    logic [2:0] m;
    m = g_mb[3:1];
    if (first || !g_mb[4]) begin
      p1 = g_b1; p2 = g_b2;
    end else begin
      if (m >= 3'd2 && m <= 3'd5) p1 = g_b1;
      if (m >= 3'd3 && m <= 3'd5) p2 = p2 + 16'd1;
    end
    for (int c = 0; c < 57; c++) begin
      cyc(c);
      if (first && c == 0) do_load();
    end
    @(negedge clk);
    mc_tick = 1'b0;
    #5;
    chk(ml_end == exp_end, "R11", "ml_end after line", ml_end, exp_end);
  endtask

  initial begin
    rst_n = 1'b0; prm_load = 1'b0; mc_tick = 1'b0; mc_index = '0; idx_byte = '0;
    prm_count = '0; prm_mode = '0; prm_lmarg = '0; prm_rmarg = '0;
    prm_ptr_a = '0; prm_ptr_b = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #5;
    chk(fa_en == 1'b0, "R1", "fa_en reset", fa_en, 0);
    chk(fb_en == 1'b0, "R1", "fb_en reset", fb_en, 0);
    chk(sync_win == 1'b0, "R1", "sync_win reset", sync_win, 0);
    chk(ml_end == 1'b0, "R1", "ml_end reset", ml_end, 0);

    // R3 R8: full bitmap, continue, two scanlines
    setup(8'hFE, 4'b1001, 6'd10, 6'd20, 16'h1000, 16'h0000, "R3 R8");
    run_line(1, 0); run_line(0, 1);
    // R4 R9: half bitmap, margins cover reserved cycles
    setup(8'hFF, 4'b1111, 6'd0, 6'd63, 16'h5550, 16'h0000, "R4 R9");
    run_line(1, 1);
    // R5: cell attribute, two scanlines
    setup(8'hFE, 4'b1010, 6'd8, 6'd12, 16'h2000, 16'h3000, "R5");
    run_line(1, 0); run_line(0, 1);
    // R6 R7: glyph-256, two scanlines
    setup(8'hFE, 4'b1011, 6'd8, 6'd11, 16'h4000, 16'h0012, "R6 R7");
    run_line(1, 0); run_line(0, 1);
    // R6: glyph-128 and glyph-64 splices
    setup(8'hFF, 4'b1100, 6'd20, 6'd24, 16'h4100, 16'hF155, "R6");
    run_line(1, 1);
    setup(8'hFF, 4'b1101, 6'd50, 6'd60, 16'h4200, 16'hF2AB, "R6 R9");
    run_line(1, 1);
    // R10: repeat mode, bitmap then cell attribute
    setup(8'hFD, 4'b0001, 6'd30, 6'd33, 16'h7000, 16'h0000, "R10");
    run_line(1, 0); run_line(0, 0); run_line(0, 1);
    setup(8'hFE, 4'b0010, 6'd9, 6'd13, 16'h7800, 16'h7900, "R10");
    run_line(1, 0); run_line(0, 1);
    // R2: sync band window
    setup(8'hFF, 4'b1000, 6'd3, 6'd40, 16'h0000, 16'h0000, "R2");
    run_line(1, 1);
    // R12: reserved code
    setup(8'hFF, 4'b1110, 6'd0, 6'd63, 16'h0100, 16'h0200, "R12");
    run_line(1, 1);

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R1", "scoreboard drained", q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule